// File: doc/BRIEF.md
# Cascadable Two-Unit Pulse Generator

The block holds two reload down-counters. Each counter has its own reload value for the low phase and its own reload value for the high phase, so its pin produces a waveform with separately programmed low and high durations. The pair can run in three ways. It can act as two independent 8-bit generators. It can act as one 16-bit generator whose reload values are formed by joining the two units' values. It can also act as an 8-bit prescaler that paces an 8-bit generator. Every counter step is taken on a count tick, and that tick is chosen from the system clock divided by 1, 2, 4, 8 or 16, or from a slow fixed tick.

Software loads the four reload registers through a plain write port. It picks the mode and the tick source, then raises `enable`. The mode and tick source are changed only while `enable` is low. Each unit raises a sticky flag when its high phase runs out, and the flag stays up until it is cleared. The block carries configuration only and has no data stream, so every pin is a plain level or strobe with no valid/ready handshake. A write is accepted in the cycle that `wr_en` is high, and the block never applies back-pressure.

Top module: `pulse_pair_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pulse0`, `pulse1`, `flag0` and `flag1` are 0.
- R2: While `enable` is low both pins are low and no counting takes place. If `enable` is dropped in the middle of a phase, the pin is low from the next clock onward, and no flag is set by that stop.
- R3: In mode 00 (dual) each unit starts low after `enable` rises. Its pin stays low for L+1 ticks and then high for H+1 ticks, and this repeats. Unit 0 uses address 0 as L and address 1 as H. Unit 1 uses address 2 as L and address 3 as H.
- R4: `clk_sel` values 0, 1, 2, 3 and 4 give one tick every 1, 2, 4, 8 and 16 clocks. Values 5 to 7 give one tick every SLOW_DIV clocks. The divider restarts when `enable` rises, so a phase with reload N lasts exactly (N+1) times the tick period in clocks.
- R5: In mode 01 (joined) `pulse1` is driven by one 16-bit counter. Its low reload is {addr2, addr0} and its high reload is {addr3, addr1}. `pulse0` stays low.
- R6: In mode 10 (prescaler) unit 0 reloads address 0 at every underflow and divides the tick by value+1. Address 1 is unused. Unit 1 steps once per prescaler underflow, and `pulse0` stays low.
- R7: A unit's flag is set on the clock where its pin falls because the high count ran out. `flag0` can be set only in mode 00. A flag holds until its `flag_clr` bit is high at a clock. If set and clear fall in the same clock, set wins.
- R8: A reload register written while the unit runs does not change the phase already in progress. The new value is used at the next load of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run when high; stop and force pins low when low |
| mode | input | 2 | 00 dual, 01 joined 16-bit, 10 prescaler, 11 as dual |
| clk_sel | input | 3 | Count tick source select |
| wr_en | input | 1 | Reload register write strobe |
| wr_addr | input | 2 | 0 unit0 low, 1 unit0 high, 2 unit1 low, 3 unit1 high |
| wr_data | input | W | Reload value |
| flag_clr | input | 2 | Per-unit flag clear (bit 0 unit 0, bit 1 unit 1) |
| pulse0 | output | 1 | Unit 0 waveform |
| pulse1 | output | 1 | Unit 1 (or joined) waveform |
| flag0 | output | 1 | Unit 0 high-phase-end flag |
| flag1 | output | 1 | Unit 1 high-phase-end flag |

## Verification
Two pairs of events can land on the same clock. The first pair is a flag set and a flag clear. The bench times a one-cycle `flag_clr` so that it sits on the clock where `pulse1` leaves its high phase, expects `flag1` to read 1 afterwards, and then clears it on a quiet clock and expects 0. The second pair is a reload write and a phase in progress. The bench writes a new low width in the middle of a low phase. It expects the running phase to keep the old length and the following low phase to take the new one.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8    = 2'b00,
    MODE_JOIN16   = 2'b01,
    MODE_PRESCALE = 2'b10,
    MODE_RSVD     = 2'b11
  } ppg_mode_e;

  localparam logic [1:0] ADDR_LO0 = 2'd0;
  localparam logic [1:0] ADDR_HI0 = 2'd1;
  localparam logic [1:0] ADDR_LO1 = 2'd2;
  localparam logic [1:0] ADDR_HI1 = 2'd3;
endpackage

// File: rtl/ppg_reload_regs.sv
`timescale 1ns/1ps
module ppg_reload_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo0,
  output logic [W-1:0] hi0,
  output logic [W-1:0] lo1,
  output logic [W-1:0] hi1
);
  import ppg_pkg::*;
  localparam int NREG = 4;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign lo0 = regs[ADDR_LO0];
  assign hi0 = regs[ADDR_HI0];
  assign lo1 = regs[ADDR_LO1];
  assign hi1 = regs[ADDR_HI1];
endmodule

// File: rtl/ppg_tick_gen.sv
`timescale 1ns/1ps
module ppg_tick_gen #(
  parameter int SLOW_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int DIV_W   = $clog2(SLOW_DIV);
  localparam int MAX_POW = 4;

  logic [DIV_W-1:0] divcnt;
  logic [DIV_W-1:0] mask;

  // divider restarts from zero whenever the block is stopped
  always_ff @(posedge clk) begin
    if (!rst_n || !run) divcnt <= '0;
    else                divcnt <= divcnt + DIV_W'(1);
  end

  // a tick fires when the selected low bits of the divider are all ones
  always_comb begin
    if (int'(sel) <= MAX_POW) mask = (DIV_W'(1) << sel) - DIV_W'(1);
    else                      mask = '1;
  end

  assign tick = run && ((divcnt & mask) == mask);
endmodule

// File: rtl/ppg_phase_counter.sv
`timescale 1ns/1ps
module ppg_phase_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] lo_val,
  input  logic [CW-1:0] hi_val,
  output logic          phase,
  output logic          wrap
);
  logic [CW-1:0] cnt;

  assign wrap = run && step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= lo_val;
      phase <= 1'b0;
    end else if (step) begin
      if (cnt == '0) begin
        phase <= ~phase;
        cnt   <= phase ? lo_val : hi_val;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/pulse_pair_gen.sv
`timescale 1ns/1ps
module pulse_pair_gen #(
  parameter int W        = 8,
  parameter int SLOW_DIV = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [1:0]   mode,
  input  logic [2:0]   clk_sel,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   flag_clr,
  output logic         pulse0,
  output logic         pulse1,
  output logic         flag0,
  output logic         flag1
);
  import ppg_pkg::*;
  localparam int W2 = 2 * W;

  ppg_mode_e    md;
  logic         join16, presc, dual;
  logic [W-1:0] lo0, hi0, lo1, hi1;
  logic         tick;
  logic         run0, phase0, wrap0;
  logic         step1, phase1, wrap1;
  logic [W2-1:0] lo_wide, hi_wide;
  logic [W-1:0] hi0_eff;
  logic         set0, set1;

  assign md     = ppg_mode_e'(mode);
  assign join16 = (md == MODE_JOIN16);
  assign presc  = (md == MODE_PRESCALE);
  assign dual   = !join16 && !presc;

  ppg_reload_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1)
  );

  ppg_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(enable), .sel(clk_sel), .tick(tick)
  );

  // unit 0: own generator in dual mode, divider in prescaler mode, idle when joined
  assign run0    = enable && !join16;
  assign hi0_eff = presc ? lo0 : hi0;

  ppg_phase_counter #(.CW(W)) u_unit0 (
    .clk(clk), .rst_n(rst_n), .run(run0), .step(tick),
    .lo_val(lo0), .hi_val(hi0_eff), .phase(phase0), .wrap(wrap0)
  );

  // unit 1: double width so the joined mode reuses it
  assign lo_wide = join16 ? {lo1, lo0} : {{W{1'b0}}, lo1};
  assign hi_wide = join16 ? {hi1, hi0} : {{W{1'b0}}, hi1};
  assign step1   = presc ? wrap0 : tick;

  ppg_phase_counter #(.CW(W2)) u_unit1 (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(step1),
    .lo_val(lo_wide), .hi_val(hi_wide), .phase(phase1), .wrap(wrap1)
  );

  assign pulse0 = dual && phase0;
  assign pulse1 = phase1;

  // high phase ends when the counter wraps while the pin is high
  assign set0 = dual && wrap0 && phase0;
  assign set1 = wrap1 && phase1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      flag0 <= set0 || (flag0 && !flag_clr[0]);
      flag1 <= set1 || (flag1 && !flag_clr[1]);
    end
  end
endmodule

// File: rtl/ppg_checks.sv
`timescale 1ns/1ps
module ppg_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] flag_clr,
  input logic       pulse0,
  input logic       pulse1,
  input logic       flag0,
  input logic       flag1
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pulse0 && !pulse1));

  p_rise_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse1) |-> $past(enable));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (!pulse0 && !pulse1));

  p_flag_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag1) |-> $fell(pulse1));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !flag_clr[0]) |=> flag0);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr[1] |=> (!flag1 || $fell(pulse1)));
endmodule

bind pulse_pair_gen ppg_checks u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .flag_clr(flag_clr),
  .pulse0(pulse0), .pulse1(pulse1), .flag0(flag0), .flag1(flag1)
);

// File: tb/pulse_pair_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_pair_gen_tb_top;
  localparam int W = 8;
  localparam int SLOW_DIV = 32;
  localparam int LIMIT = 10000;
  localparam int NVEC = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] clk_sel = 3'd0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] flag_clr = 2'b00;
  logic pulse0, pulse1, flag0, flag1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_pair_gen #(.W(W), .SLOW_DIV(SLOW_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .clk_sel(clk_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr),
    .pulse0(pulse0), .pulse1(pulse1), .flag0(flag0), .flag1(flag1)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [2:0]  sel;
    logic [7:0]  lo0, hi0, lo1, hi1;
    logic [15:0] exp_lo, exp_hi;
  } vec_t;

  // expected pulse1 low/high lengths in clocks, from R3..R6
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd0, 8'd5,  8'd5, 8'd3,   8'd6, 16'd4,    16'd7},
    '{2'd0, 3'd0, 8'd0,  8'd0, 8'd0,   8'd0, 16'd1,    16'd1},
    '{2'd0, 3'd2, 8'd0,  8'd0, 8'd2,   8'd1, 16'd12,   16'd8},
    '{2'd0, 3'd5, 8'd0,  8'd0, 8'd1,   8'd0, 16'd64,   16'd32},
    '{2'd1, 3'd0, 8'd2,  8'd3, 8'd1,   8'd0, 16'd259,  16'd4},
    '{2'd2, 3'd0, 8'd3,  8'd9, 8'd2,   8'd1, 16'd12,   16'd8},
    '{2'd2, 3'd1, 8'd1,  8'd0, 8'd1,   8'd2, 16'd8,    16'd12},
    '{2'd0, 3'd4, 8'd0,  8'd0, 8'd0,   8'd1, 16'd16,   16'd32},
    '{2'd0, 3'd3, 8'd0,  8'd0, 8'd255, 8'd0, 16'd2048, 16'd8}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  // enable at a falling edge, then time the first low and high phase of a pin
  task automatic measure(input bit pin1, output int lo_n, output int hi_n, output bit p0_seen);
    lo_n = 0; hi_n = 0; p0_seen = 1'b0;
    @(negedge clk); enable = 1'b1;
    do begin
      @(negedge clk); lo_n++; p0_seen |= pulse0;
    end while (!(pin1 ? pulse1 : pulse0) && lo_n < LIMIT);
    do begin
      @(negedge clk); hi_n++; p0_seen |= pulse0;
    end while ((pin1 ? pulse1 : pulse0) && hi_n < LIMIT);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo_n, hi_n, k;
    bit p0;
    string tag;

    repeat (3) @(negedge clk);
    check(pulse0 == 0 && pulse1 == 0, "R1 pins in reset", int'({pulse0, pulse1}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse0 == 0, "R1 pulse0 after reset", int'(pulse0), 0);
    check(pulse1 == 0, "R1 pulse1 after reset", int'(pulse1), 0);
    check(flag0 == 0 && flag1 == 0, "R1 flags after reset", int'({flag0, flag1}), 0);

    // table walk: modes and tick sources
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk); enable = 1'b0;
      mode = VECS[i].md; clk_sel = VECS[i].sel;
      wr(2'd0, VECS[i].lo0); wr(2'd1, VECS[i].hi0);
      wr(2'd2, VECS[i].lo1); wr(2'd3, VECS[i].hi1);
      repeat (2) @(negedge clk);
      measure(1'b1, lo_n, hi_n, p0);
      tag = (VECS[i].md == 2'd1) ? "R5" : (VECS[i].md == 2'd2) ? "R6" :
            (VECS[i].sel != 3'd0) ? "R4" : "R3";
      check(lo_n == int'(VECS[i].exp_lo), {tag, " low length"}, lo_n, int'(VECS[i].exp_lo));
      check(hi_n == int'(VECS[i].exp_hi), {tag, " high length"}, hi_n, int'(VECS[i].exp_hi));
      if (VECS[i].md != 2'd0)
        check(!p0, {tag, " pulse0 held low"}, int'(p0), 0);
    end

    // R3 / R7: unit 0 in dual mode and its flag
    @(negedge clk); enable = 1'b0; mode = 2'd0; clk_sel = 3'd0;
    wr(2'd0, 8'd2); wr(2'd1, 8'd1);
    clear_flags();
    check(flag0 == 0, "R7 flag0 cleared", int'(flag0), 0);
    measure(1'b0, lo_n, hi_n, p0);
    check(lo_n == 3, "R3 unit0 low length", lo_n, 3);
    check(hi_n == 2, "R3 unit0 high length", hi_n, 2);
    check(flag0 == 1, "R7 flag0 set at high end", int'(flag0), 1);

    // R7: set and clear on the same clock
    @(negedge clk); enable = 1'b0;
    wr(2'd2, 8'd1); wr(2'd3, 8'd1);
    clear_flags();
    @(negedge clk); enable = 1'b1;
    k = 0;
    while (!pulse1 && k < LIMIT) begin @(negedge clk); k++; end
    @(negedge clk);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    check(pulse1 == 0, "R7 pulse1 fell", int'(pulse1), 0);
    check(flag1 == 1, "R7 set wins over clear", int'(flag1), 1);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    check(flag1 == 0, "R7 clear on quiet clock", int'(flag1), 0);

    // R2: stop in the middle of a high phase
    @(negedge clk); enable = 1'b0;
    wr(2'd2, 8'd3); wr(2'd3, 8'd5);
    clear_flags();
    @(negedge clk); enable = 1'b1;
    k = 0;
    while (!pulse1 && k < LIMIT) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(pulse1 == 0, "R2 pin low after stop", int'(pulse1), 0);
    check(flag1 == 0, "R2 no flag from stop", int'(flag1), 0);
    repeat (6) @(negedge clk);
    check(pulse1 == 0 && pulse0 == 0, "R2 pins stay low while stopped", int'({pulse0, pulse1}), 0);

    // R8: reload write during a running low phase
    wr(2'd2, 8'd9); wr(2'd3, 8'd9);
    @(negedge clk); enable = 1'b1;
    lo_n = 0;
    do begin
      @(negedge clk); lo_n++;
      if (lo_n == 3) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd2; end
      if (lo_n == 4) wr_en = 1'b0;
    end while (!pulse1 && lo_n < LIMIT);
    hi_n = 0;
    do begin @(negedge clk); hi_n++; end while (pulse1 && hi_n < LIMIT);
    k = 0;
    do begin @(negedge clk); k++; end while (!pulse1 && k < LIMIT);
    check(lo_n == 10, "R8 running phase keeps old width", lo_n, 10);
    check(hi_n == 10, "R8 high width", hi_n, 10);
    check(k == 3, "R8 next low phase uses new width", k, 3);

    @(negedge clk); enable = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule